// File: doc/BRIEF.md
# Bus-Attached Seconds Counter with Match Alarm

This block keeps a free-running 32-bit count of elapsed seconds. A prescaler divides the system clock down to a one-cycle tick once per second, and the count advances by one on each tick, wrapping from all-ones back to zero. Software reaches the block through a small register bus that decodes byte offsets inside a 4 KB window. Through that bus it can preload the count, program a match value, mask the alarm, and clear it.

Whenever the count becomes equal to the match value, a raw alarm flag is set. The count can get there on a tick, including one that wraps the count, or directly through a write to the match or load register. The raw flag, gated by a one-bit mask, drives a level-sensitive interrupt output. The flag stays set until software writes the clear register. The last 32 bytes of the window return a fixed identification byte sequence, one byte per word.

The bus is a plain single-cycle strobe: select, write enable, address and write data are sampled on one clock edge. A read returns its data on the cycle after the select. There is no back-pressure, so every access completes in one cycle.

Top module: `sec_alarm_counter`

## Requirements
- R1: After reset the count, match, load, mask and raw alarm registers all read 0 and `alarm_irq` is low.
- R2: The count rises by exactly one on each tick. There is one tick every `TICK_DIV` clock cycles, and it lasts one cycle. The count wraps from 0xFFFFFFFF to 0.
- R3: A write to offset 0x08 replaces the count with the written value from the next cycle, and takes priority over a tick in the same cycle. A read of 0x08 returns the value last written there.
- R4: Offset 0x04 holds the match value, which reads back as written.
- R5: Raw status (offset 0x14, bit 0) sets when a tick brings the count equal to the match value, also when the tick wraps the count.
- R6: A write to 0x04 or 0x08 that leaves the count equal to the match value sets raw status at once, so it reads 1 on the next access.
- R7: Any write to offset 0x1C clears raw status, whatever its data. A read of 0x1C returns 0. The flag sets again only on a new equality event.
- R8: The mask at offset 0x10 stores bit 0 of the written data only. `alarm_irq` and the masked status at 0x18 (bit 0) both equal raw status AND mask.
- R9: The control register at 0x0C always reads 1, and writes to it change nothing.
- R10: Word reads at 0xFE0, 0xFE4, up to 0xFFC return in turn 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Writes to 0x00, 0x14, 0x18 or to undecoded offsets change no state. Reads of undecoded or unaligned offsets return 0.
- R12: Read data appears on `bus_rdata` the cycle after a select with `bus_wr` low. In every other cycle `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by `bus_sel` |
| bus_addr | input | 12 | Byte offset inside the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read select |
| alarm_irq | output | 1 | Level interrupt: raw alarm AND mask |

## Verification
The checker watches several properties on every cycle. It checks that the tick lasts only one cycle. It checks that the count holds, steps by one, or takes a loaded value exactly as the tick and bus writes dictate. It checks that the alarm flag falls only after a clear write, and that the interrupt never rises while the mask is off. It also checks the control read value and the idle read bus. The bench scenarios cover the value-level behaviour that spans many cycles or depends on data. That includes an alarm reached by counting, including across a wrap. It also includes immediate equality after a load or match write, mask and masked-status readback, the identification bytes, and the absence of side effects from writes to read-only and undecoded offsets.

// File: rtl/sac_pkg.sv
`timescale 1ns/1ps
package sac_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_COUNT = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_MATCH = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_LOAD  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_MSKD  = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h01C;

  // identification area: top 32 bytes of the window, one byte per word
  localparam logic [6:0] ID_AREA_TOP = 7'h7F;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    id_byte = 8'h31;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h14;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/sac_tick_gen.sv
`timescale 1ns/1ps
module sac_tick_gen #(
  parameter int TICK_DIV = 200_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (div_q == LAST) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign tick_o = (div_q == LAST);
endmodule

// File: rtl/sac_alarm_core.sv
`timescale 1ns/1ps
module sac_alarm_core
  import sac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              we_load_i,
  input  logic              we_match_i,
  input  logic              we_mask_i,
  input  logic              we_clear_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] count_o,
  output logic [DATA_W-1:0] match_o,
  output logic [DATA_W-1:0] load_o,
  output logic              mask_o,
  output logic              raw_o
);
  logic [DATA_W-1:0] count_q, match_q, load_q;
  logic [DATA_W-1:0] count_d, match_d;
  logic              mask_q, raw_q;
  logic              eq_event;

  always_comb begin
    count_d = count_q;
    if (we_load_i)   count_d = wdata_i;
    else if (tick_i) count_d = count_q + 1'b1;
    match_d  = we_match_i ? wdata_i : match_q;
    // equality counts only when something moved the count or the match
    eq_event = (tick_i | we_load_i | we_match_i) && (count_d == match_d);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      match_q <= '0;
      load_q  <= '0;
      mask_q  <= 1'b0;
      raw_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      match_q <= match_d;
      if (we_load_i) load_q <= wdata_i;
      if (we_mask_i) mask_q <= wdata_i[0];
      // a fresh equality wins over a clear in the same cycle
      if (eq_event)        raw_q <= 1'b1;
      else if (we_clear_i) raw_q <= 1'b0;
    end
  end

  assign count_o = count_q;
  assign match_o = match_q;
  assign load_o  = load_q;
  assign mask_o  = mask_q;
  assign raw_o   = raw_q;
endmodule

// File: rtl/sac_read_mux.sv
`timescale 1ns/1ps
module sac_read_mux
  import sac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic [DATA_W-1:0] match_i,
  input  logic [DATA_W-1:0] load_i,
  input  logic              mask_i,
  input  logic              raw_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] sel_val;
  logic              in_id_area;

  assign in_id_area = (addr_i[ADDR_W-1:5] == ID_AREA_TOP) && (addr_i[1:0] == 2'b00);

  always_comb begin
    sel_val = '0;
    if (in_id_area) begin
      sel_val = DATA_W'(id_byte(addr_i[4:2]));
    end else begin
      case (addr_i)
        OFS_COUNT: sel_val = count_i;
        OFS_MATCH: sel_val = match_i;
        OFS_LOAD:  sel_val = load_i;
        OFS_CTRL:  sel_val = DATA_W'(1);
        OFS_MASK:  sel_val = DATA_W'(mask_i);
        OFS_RAW:   sel_val = DATA_W'(raw_i);
        OFS_MSKD:  sel_val = DATA_W'(raw_i & mask_i);
        default:   sel_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_o <= '0;
    else        rdata_o <= rd_en_i ? sel_val : '0;
  end
endmodule

// File: rtl/sec_alarm_counter.sv
`timescale 1ns/1ps
module sec_alarm_counter
  import sac_pkg::*;
#(
  parameter int TICK_DIV = 200_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              alarm_irq
);
  logic              tick;
  logic              wr_cyc, rd_cyc;
  logic              we_load, we_match, we_mask, we_clear;
  logic [DATA_W-1:0] count_w, match_w, load_w;
  logic              mask_w, raw_w;

  assign wr_cyc   = bus_sel & bus_wr;
  assign rd_cyc   = bus_sel & ~bus_wr;
  assign we_load  = wr_cyc & (bus_addr == OFS_LOAD);
  assign we_match = wr_cyc & (bus_addr == OFS_MATCH);
  assign we_mask  = wr_cyc & (bus_addr == OFS_MASK);
  assign we_clear = wr_cyc & (bus_addr == OFS_CLR);

  sac_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  sac_alarm_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .we_load_i  (we_load),
    .we_match_i (we_match),
    .we_mask_i  (we_mask),
    .we_clear_i (we_clear),
    .wdata_i    (bus_wdata),
    .count_o    (count_w),
    .match_o    (match_w),
    .load_o     (load_w),
    .mask_o     (mask_w),
    .raw_o      (raw_w)
  );

  sac_read_mux u_rmux (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en_i (rd_cyc),
    .addr_i  (bus_addr),
    .count_i (count_w),
    .match_i (match_w),
    .load_i  (load_w),
    .mask_i  (mask_w),
    .raw_i   (raw_w),
    .rdata_o (bus_rdata)
  );

  assign alarm_irq = raw_w & mask_w;
endmodule

// File: rtl/sac_checker.sv
`timescale 1ns/1ps
module sac_checker
  import sac_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              alarm_irq,
  input logic              tick,
  input logic [DATA_W-1:0] count,
  input logic              raw,
  input logic              mask
);
  logic ld_wr, clr_wr, ctrl_rd;
  assign ld_wr   = bus_sel && bus_wr && (bus_addr == OFS_LOAD);
  assign clr_wr  = bus_sel && bus_wr && (bus_addr == OFS_CLR);
  assign ctrl_rd = bus_sel && !bus_wr && (bus_addr == OFS_CTRL);

  a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  a_r2_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_wr && !tick) |=> (count == $past(count)));

  a_r2_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_wr && tick) |=> (count == $past(count) + 1'b1));

  a_r3_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr |=> (count == $past(bus_wdata)));

  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !tick) |=> !raw);

  a_r7_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(raw) |-> $past(clr_wr));

  a_r8_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> mask);

  a_r9_ctrl_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd |=> (bus_rdata == DATA_W'(1)));

  a_r12_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> (bus_rdata == '0));
endmodule

bind sec_alarm_counter sac_checker u_sac_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .alarm_irq (alarm_irq),
  .tick      (tick),
  .count     (count_w),
  .raw       (raw_w),
  .mask      (mask_w)
);

// File: tb/sec_alarm_counter_bench.sv
`timescale 1ns/1ps
module sec_alarm_counter_bench;
  localparam int DIV = 20;
  localparam logic [11:0] A_CNT = 12'h000, A_MAT = 12'h004, A_LD = 12'h008,
                          A_CTL = 12'h00C, A_MSK = 12'h010, A_RAW = 12'h014,
                          A_MIS = 12'h018, A_CLR = 12'h01C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        alarm_irq;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  sec_alarm_counter #(.TICK_DIV(DIV)) u_sec_alarm_counter (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alarm_irq(alarm_irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wrt(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  // returns just after a tick, leaving about DIV-3 tick-free cycles
  task automatic sync_tick();
    logic [31:0] a, b;
    rd(A_CNT, a);
    b = a;
    while (b == a) rd(A_CNT, b);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CNT, v); chk("R1 count", v, 0);
    rd(A_MAT, v); chk("R1 match", v, 0);
    rd(A_LD, v);  chk("R1 load", v, 0);
    rd(A_MSK, v); chk("R1 mask", v, 0);
    rd(A_RAW, v); chk("R1 raw", v, 0);
    chk("R1 irq", 32'(alarm_irq), 0);
    @(negedge clk);
    chk("R12 idle rdata", bus_rdata, 0);
  endtask

  task automatic t_count_run();
    logic [31:0] c0, c1, c2;
    rd(A_CNT, c0);
    repeat (DIV - 1) @(negedge clk);
    rd(A_CNT, c1); chk("R2 one tick", c1, c0 + 1);
    repeat (3 * DIV - 1) @(negedge clk);
    rd(A_CNT, c2); chk("R2 three ticks", c2, c1 + 3);
  endtask

  task automatic t_load_wrap();
    logic [31:0] v;
    sync_tick();
    wrt(A_LD, 32'hFFFF_FFFF);
    rd(A_CNT, v); chk("R3 load count", v, 32'hFFFF_FFFF);
    rd(A_LD, v);  chk("R3 load readback", v, 32'hFFFF_FFFF);
    repeat (DIV - 2) @(negedge clk);
    rd(A_CNT, v); chk("R2 wrap to zero", v, 0);
    rd(A_RAW, v); chk("R5 alarm at wrap", v, 1);
  endtask

  task automatic t_match_tick();
    logic [31:0] v;
    wrt(A_CLR, 32'h0);
    sync_tick();
    wrt(A_LD, 32'd100);
    wrt(A_MAT, 32'd103);
    rd(A_MAT, v); chk("R4 match readback", v, 32'd103);
    rd(A_RAW, v); chk("R5 not early", v, 0);
    repeat (4 * DIV) @(negedge clk);
    rd(A_RAW, v); chk("R5 alarm by tick", v, 1);
    rd(A_CNT, v);
    total++;
    if (v < 32'd103 || v > 32'd104) begin
      bad++;
      $display("FAIL R5 count near match: actual=%h expected=%h..%h", v, 32'd103, 32'd104);
    end
  endtask

  task automatic t_immediate();
    logic [31:0] v;
    wrt(A_CLR, 32'h0);
    sync_tick();
    wrt(A_MAT, 32'd500);
    wrt(A_LD, 32'd500);
    rd(A_RAW, v); chk("R6 load equal", v, 1);
    wrt(A_CLR, 32'h0);
    rd(A_RAW, v); chk("R7 stays clear while equal", v, 0);
    wrt(A_LD, 32'd42);
    rd(A_RAW, v); chk("R6 unequal load", v, 0);
    wrt(A_MAT, 32'd42);
    rd(A_RAW, v); chk("R6 match equal", v, 1);
  endtask

  task automatic t_mask_clear();
    logic [31:0] v;
    wrt(A_MSK, 32'hFFFF_FFFE);
    rd(A_MSK, v); chk("R8 mask bit0 only", v, 0);
    chk("R8 irq masked", 32'(alarm_irq), 0);
    rd(A_MIS, v); chk("R8 masked status off", v, 0);
    wrt(A_MSK, 32'h0000_0001);
    chk("R8 irq on", 32'(alarm_irq), 1);
    rd(A_MIS, v); chk("R8 masked status on", v, 1);
    rd(A_MSK, v); chk("R8 mask readback", v, 1);
    wrt(A_CLR, 32'hDEAD_0000);
    rd(A_RAW, v); chk("R7 any data clears", v, 0);
    chk("R7 irq low after clear", 32'(alarm_irq), 0);
    rd(A_CLR, v); chk("R7 clear reads 0", v, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wrt(A_CTL, 32'h0);
    rd(A_CTL, v); chk("R9 ctrl after 0", v, 1);
    wrt(A_CTL, 32'hFFFF_FFFF);
    rd(A_CTL, v); chk("R9 ctrl after ones", v, 1);
  endtask

  task automatic t_id();
    logic [31:0] v;
    logic [7:0] exp_id [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) begin
      rd(12'hFE0 + 12'(4 * i), v);
      chk("R10 id byte", v, 32'(exp_id[i]));
    end
  endtask

  task automatic t_readonly();
    logic [31:0] v;
    wrt(A_CLR, 32'h0);
    sync_tick();
    wrt(A_LD, 32'd7);
    wrt(A_MAT, 32'd7);
    wrt(A_CNT, 32'h1234);
    rd(A_CNT, v); chk("R11 count write ignored", v, 32'd7);
    wrt(A_RAW, 32'h0);
    wrt(A_MIS, 32'h0);
    rd(A_RAW, v); chk("R11 status write ignored", v, 1);
    wrt(12'h020, 32'd55);
    wrt(12'h800, 32'd9);
    rd(A_MAT, v); chk("R11 match untouched", v, 32'd7);
    rd(A_LD, v);  chk("R11 load untouched", v, 32'd7);
    rd(12'h020, v); chk("R11 undecoded read", v, 0);
    rd(12'h006, v); chk("R11 unaligned read", v, 0);
    rd(12'hFC0, v); chk("R11 below id area", v, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_run();
    t_load_wrap();
    t_match_tick();
    t_immediate();
    t_mask_clear();
    t_ctrl();
    t_id();
    t_readonly();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog (R1..R12 run): actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule